// File: doc/BRIEF.md
# Latched-Address Register Bus Slave

This block lets a local microprocessor read and write a bank of internal registers over an asynchronous parallel bus. The bus has separate active-low read and write strobes and an active-high address-latch strobe. The host presents a 9-bit address and pulses the latch strobe, and the slave keeps the address it saw when that strobe fell. The host then lowers either the read strobe or the write strobe while chip select is low. On a read, the slave drives the addressed word onto its data outputs. On a write, it stores the data word it sees when the write strobe rises. An active-low ready output tells the host when it may end the cycle. Until then the host inserts wait states.

Every strobe and the chip select pass through a two-flop synchronizer on the system clock. The state machine acts on edges of these synchronized copies. The tri-state data bus is split into three parts: a data input, a data output and one output enable for each byte lane. A width pin selects a 16-bit or 8-bit bus. A mode pin selects an alternate bus personality, which this block does not serve. In that mode the block stays quiet.

An interrupt unit sits at the top two addresses. Each source sets a sticky pending bit. Writing a 1 to a pending bit clears it. The active-low interrupt output is asserted while any pending bit is also enabled.

The state machine has four states:
- ST_IDLE: no cycle is active.
- ST_RD_FETCH: the read word is being captured.
- ST_RD_DRIVE: the read word is driven onto the bus.
- ST_WR_HOLD: the write cycle is acknowledged and waits for the write strobe to rise.

Its transitions are:
- IDLE→RD_FETCH: on a synchronized read fall while chip select is low.
- IDLE→WR_HOLD: on a synchronized write fall while chip select is low.
- RD_FETCH→RD_DRIVE: always, one clock later.
- RD_DRIVE→IDLE: on a synchronized read rise.
- WR_HOLD→IDLE: on a synchronized write rise. The write is committed here only if chip select is still low.
- Any state→IDLE: when the alternate mode is selected.

Top module: `latched_bus_slave`

## Requirements
- R1: In reset and just after it, ready_n_o is 1, data_oe_o is 2'b00 and irq_n_o is 1.
- R2: The slave captures the address from addr_i when ale_i falls. A change of addr_i after that fall does not change which location is accessed.
- R3: After rd_n_i falls with cs_n_i low, ready_n_o goes low on the 4th rising clock edge. The data outputs are enabled with the addressed word and hold steady. The enables turn off and ready_n_o returns to 1 on the 3rd rising clock edge after rd_n_i rises.
- R4: A write stores the data_i value present when wr_n_i rises. Values driven earlier in the same cycle are not stored.
- R5: While cs_n_i is high, strobes start no cycle. ready_n_o stays 1, the enables stay off and no location changes.
- R6: With wide16_i = 1, writes store all 16 bits, reads return all 16 bits and both lane enables are asserted.
- R7: With wide16_i = 0, a write changes only bits [7:0] of the location. A read drives data_o[15:8] = 0 with only data_oe_o[0] asserted.
- R8: With mode_alt_i = 1, the read, write and latch strobes are ignored. The enables stay off, ready_n_o stays 1 and no location changes.
- R9: Address 0x1FE holds the interrupt enable bits. Address 0x1FF holds the pending bits. A pending bit is set by a high irq_src_i bit and stays set. Writing a 1 to a pending bit clears it. irq_n_o is 0 exactly when (pending & enable) is nonzero.
- R10: During a write cycle, ready_n_o goes low while wr_n_i is still low. A write commit happens only during that ready window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_alt_i | input | 1 | 1 selects the unserved alternate bus personality |
| wide16_i | input | 1 | 1 selects a 16-bit bus, 0 selects an 8-bit bus |
| cs_n_i | input | 1 | Active-low chip select |
| ale_i | input | 1 | Active-high address latch strobe; the address is taken when it falls |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe; the write commits when it rises |
| addr_i | input | 9 | Register address |
| data_i | input | 16 | Data from the host |
| data_o | output | 16 | Read data to the host |
| data_oe_o | output | 2 | Per-byte-lane output enable, bit 1 for the upper lane |
| ready_n_o | output | 1 | Active-low ready |
| irq_n_o | output | 1 | Active-low interrupt request (open-drain level) |
| irq_src_i | input | 8 | Interrupt source levels |

## Verification
The hardest case to reach is a host that changes its inputs within the synchronizer window. Examples are data that changes before the write strobe rises, an address bus that moves right after the latch strobe falls, and a mode switch while a cycle is open. The ports alone cannot show which sample the slave kept. The bench therefore changes data_i and addr_i on purpose between the strobe edges, reads the location back through an ordinary read, and counts clock edges from each strobe transition to pin down the ready and enable timing.

// File: rtl/latched_bus_pkg.sv
package latched_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_FETCH,
        ST_RD_DRIVE,
        ST_WR_HOLD
    } bus_state_e;

    // bit positions of the synchronized strobe vector
    localparam int SIG_ALE  = 0;
    localparam int SIG_RD_N = 1;
    localparam int SIG_WR_N = 2;
    localparam int SIG_CS_N = 3;
    localparam int SIG_CNT  = 4;

endpackage

// File: rtl/latched_bus_sync.sv
module latched_bus_sync #(
    parameter int             N       = 4,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic [2:0] shift_q;   // [0],[1] synchronizer, [2] history for edge detect

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shift_q <= {3{RST_VAL[gi]}};
                end else begin
                    shift_q <= {shift_q[1:0], async_i[gi]};
                end
            end

            assign sync_o[gi] = shift_q[1];
            assign rise_o[gi] = shift_q[1] & ~shift_q[2];
            assign fall_o[gi] = ~shift_q[1] & shift_q[2];
        end
    endgenerate

endmodule

// File: rtl/latched_bus_fsm.sv
module latched_bus_fsm
    import latched_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_alt,
    input  logic       wide16,
    input  logic       cs_n_s,
    input  logic       rd_fall,
    input  logic       rd_rise,
    input  logic       wr_fall,
    input  logic       wr_rise,
    output logic       rd_load,
    output logic       wr_commit,
    output logic       ready_n,
    output logic [1:0] lane_oe
);

    bus_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!mode_alt && !cs_n_s) begin
                    if (rd_fall) begin
                        state_d = ST_RD_FETCH;
                    end else if (wr_fall) begin
                        state_d = ST_WR_HOLD;
                    end
                end
            end
            ST_RD_FETCH: begin
                state_d = mode_alt ? ST_IDLE : ST_RD_DRIVE;
            end
            ST_RD_DRIVE: begin
                if (mode_alt || rd_rise) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_HOLD: begin
                if (mode_alt || wr_rise) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        rd_load   = 1'b0;
        wr_commit = 1'b0;
        ready_n   = 1'b1;
        lane_oe   = 2'b00;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RD_FETCH: begin
                rd_load = 1'b1;
            end
            ST_RD_DRIVE: begin
                ready_n = 1'b0;
                lane_oe = {wide16, 1'b1};
            end
            ST_WR_HOLD: begin
                ready_n   = 1'b0;
                wr_commit = wr_rise && !cs_n_s && !mode_alt;
            end
        endcase
    end

endmodule

// File: rtl/latched_bus_regs.sv
module latched_bus_regs #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int N_IRQ  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide16,
    input  logic              wr_commit,
    input  logic              rd_load,
    input  logic [N_IRQ-1:0]  irq_src,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int HALF      = DATA_W / 2;
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [N_IRQ-1:0]  irq_en_q;
    logic [N_IRQ-1:0]  irq_pend_q;
    logic [N_IRQ-1:0]  pend_clr;
    logic [DATA_W-1:0] rd_val;
    logic              hit_en;
    logic              hit_pend;

    assign hit_en   = (addr == EN_ADDR);
    assign hit_pend = (addr == PEND_ADDR);
    assign pend_clr = (wr_commit && hit_pend) ? wdata[N_IRQ-1:0] : '0;

    // plain storage, no reset
    always_ff @(posedge clk) begin
        if (wr_commit && !hit_en && !hit_pend) begin
            if (wide16) begin
                mem_q[addr] <= wdata;
            end else begin
                mem_q[addr][HALF-1:0] <= wdata[HALF-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q   <= '0;
            irq_pend_q <= '0;
        end else begin
            if (wr_commit && hit_en) begin
                irq_en_q <= wdata[N_IRQ-1:0];
            end
            irq_pend_q <= (irq_pend_q & ~pend_clr) | irq_src;
        end
    end

    always_comb begin
        if (hit_en) begin
            rd_val = DATA_W'(irq_en_q);
        end else if (hit_pend) begin
            rd_val = DATA_W'(irq_pend_q);
        end else begin
            rd_val = mem_q[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_load) begin
            rd_data <= wide16 ? rd_val : {{(DATA_W-HALF){1'b0}}, rd_val[HALF-1:0]};
        end
    end

    assign irq_n = ~|(irq_pend_q & irq_en_q);

endmodule

// File: rtl/latched_bus_slave.sv
module latched_bus_slave
    import latched_bus_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int N_IRQ  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_alt_i,
    input  logic              wide16_i,
    input  logic              cs_n_i,
    input  logic              ale_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        data_oe_o,
    output logic              ready_n_o,
    output logic              irq_n_o,
    input  logic [N_IRQ-1:0]  irq_src_i
);

    localparam logic [SIG_CNT-1:0] STROBE_IDLE = 4'b1110;

    logic [SIG_CNT-1:0] strobe_raw, strobe_s, strobe_rise, strobe_fall;
    logic [ADDR_W-1:0]  addr_q;
    logic               rd_load;
    logic               wr_commit;
    logic               sync_unused;

    assign strobe_raw = {cs_n_i, wr_n_i, rd_n_i, ale_i};

    latched_bus_sync #(
        .N       (SIG_CNT),
        .RST_VAL (STROBE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_raw),
        .sync_o  (strobe_s),
        .rise_o  (strobe_rise),
        .fall_o  (strobe_fall)
    );

    assign sync_unused = ^{strobe_s[SIG_ALE], strobe_s[SIG_RD_N], strobe_s[SIG_WR_N],
                           strobe_rise[SIG_ALE], strobe_rise[SIG_CS_N],
                           strobe_fall[SIG_CS_N]};

    // address taken on the falling edge of the latch strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!mode_alt_i && strobe_fall[SIG_ALE]) begin
            addr_q <= addr_i;
        end
    end

    latched_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_alt  (mode_alt_i),
        .wide16    (wide16_i),
        .cs_n_s    (strobe_s[SIG_CS_N]),
        .rd_fall   (strobe_fall[SIG_RD_N]),
        .rd_rise   (strobe_rise[SIG_RD_N]),
        .wr_fall   (strobe_fall[SIG_WR_N]),
        .wr_rise   (strobe_rise[SIG_WR_N]),
        .rd_load   (rd_load),
        .wr_commit (wr_commit),
        .ready_n   (ready_n_o),
        .lane_oe   (data_oe_o)
    );

    latched_bus_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_IRQ  (N_IRQ)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr_q),
        .wdata     (data_i),
        .wide16    (wide16_i),
        .wr_commit (wr_commit),
        .rd_load   (rd_load),
        .irq_src   (irq_src_i),
        .rd_data   (data_o),
        .irq_n     (irq_n_o)
    );

endmodule

// File: rtl/latched_bus_checks.sv
module latched_bus_checks #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_alt_i,
    input  logic [DATA_W-1:0] data_o,
    input  logic [1:0]        data_oe_o,
    input  logic              ready_n_o,
    input  logic              irq_n_o,
    input  logic              wr_commit
);

    // R3: bus is only driven inside a ready window
    a_r3_oe_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o != 2'b00) |-> !ready_n_o);

    // R3: driven data does not move while the enables stay on
    a_r3_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_oe_o != 2'b00) && $past(data_oe_o != 2'b00)) |-> $stable(data_o));

    // R8: alternate mode leaves the bus idle from the next clock
    a_r8_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_alt_i) |-> (ready_n_o && (data_oe_o == 2'b00)));

    // R9: a raised request stays raised until a register write
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!irq_n_o) && !$past(wr_commit)) |-> !irq_n_o);

    // R10: commits fall inside the write ready window
    a_r10_commit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !ready_n_o);

endmodule

bind latched_bus_slave latched_bus_checks #(.DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_alt_i(mode_alt_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ready_n_o (ready_n_o),
    .irq_n_o   (irq_n_o),
    .wr_commit (wr_commit)
);

// File: tb/test_latched_bus_slave.sv
module test_latched_bus_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_alt_i = 1'b0;
    logic        wide16_i = 1'b1;
    logic        cs_n_i = 1'b1;
    logic        ale_i = 1'b0;
    logic        rd_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic [8:0]  addr_i = '0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic [1:0]  data_oe_o;
    logic        ready_n_o;
    logic        irq_n_o;
    logic [7:0]  irq_src_i = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    latched_bus_slave i_latched_bus_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_alt_i (mode_alt_i),
        .wide16_i   (wide16_i),
        .cs_n_i     (cs_n_i),
        .ale_i      (ale_i),
        .rd_n_i     (rd_n_i),
        .wr_n_i     (wr_n_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .ready_n_o  (ready_n_o),
        .irq_n_o    (irq_n_o),
        .irq_src_i  (irq_src_i)
    );

    // {wide, addr, write data, expected read}
    localparam logic [41:0] VECS [0:5] = '{
        {1'b1, 9'h003, 16'hA5C3, 16'hA5C3},
        {1'b1, 9'h0F0, 16'h1234, 16'h1234},
        {1'b0, 9'h0F0, 16'hFF77, 16'h0077},
        {1'b1, 9'h100, 16'h0000, 16'h0000},
        {1'b1, 9'h1A0, 16'hFFFF, 16'hFFFF},
        {1'b0, 9'h055, 16'h0080, 16'h0080}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic latch_addr(input logic [8:0] a);
        @(negedge clk);
        addr_i = a;
        ale_i  = 1'b1;
        repeat (3) @(negedge clk);
        ale_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] d);
        @(negedge clk);
        data_i = d;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        repeat (5) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (5) @(negedge clk);
        cs_n_i = 1'b1;
    endtask

    task automatic bus_read(output logic [15:0] d, output logic [1:0] oe);
        @(negedge clk);
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        repeat (6) @(negedge clk);
        d  = data_o;
        oe = data_oe_o;
        rd_n_i = 1'b1;
        repeat (5) @(negedge clk);
        cs_n_i = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [1:0]  oe;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready_n in reset", 16'(ready_n_o), 16'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", 16'(data_oe_o), 16'h0);
        check("R1 irq_n after reset", 16'(irq_n_o), 16'h1);

        // table walk: R6 / R7 write and read back
        for (int i = 0; i < 6; i++) begin
            wide16_i = VECS[i][41];
            latch_addr(VECS[i][40:32]);
            bus_write(VECS[i][31:16]);
            bus_read(rd, oe);
            check(VECS[i][41] ? "R6 table read" : "R7 table read", rd, VECS[i][15:0]);
            check(VECS[i][41] ? "R6 table lanes" : "R7 table lanes", 16'(oe), {14'b0, VECS[i][41], 1'b1});
        end

        // R7 upper byte kept by the 8-bit write
        wide16_i = 1'b1;
        latch_addr(9'h0F0);
        bus_read(rd, oe);
        check("R7 upper byte kept", rd, 16'h1277);

        // R2 address moves after latch fall
        latch_addr(9'h003);
        addr_i = 9'h0F0;
        bus_read(rd, oe);
        check("R2 latched address used", rd, 16'hA5C3);

        // R3 exact timing of ready and enables
        @(negedge clk);
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R3 ready still high at edge 3", 16'(ready_n_o), 16'h1);
        @(posedge clk);
        #2 check("R3 ready low at edge 4", 16'(ready_n_o), 16'h0);
        check("R3 lanes on", 16'(data_oe_o), 16'h3);
        @(negedge clk);
        rd_n_i = 1'b1;
        repeat (2) @(posedge clk);
        #2 check("R3 lanes held at edge 2 after rise", 16'(data_oe_o), 16'h3);
        @(posedge clk);
        #2 check("R3 lanes off at edge 3 after rise", 16'(data_oe_o), 16'h0);
        check("R3 ready high at edge 3 after rise", 16'(ready_n_o), 16'h1);
        @(negedge clk);
        cs_n_i = 1'b1;

        // R4 / R10 data sampled at write rise, ready low inside the cycle
        latch_addr(9'h020);
        @(negedge clk);
        data_i = 16'h1111;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 ready low while write strobe low", 16'(ready_n_o), 16'h0);
        data_i = 16'h2222;
        repeat (2) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (5) @(negedge clk);
        cs_n_i = 1'b1;
        bus_read(rd, oe);
        check("R4 value at write rise", rd, 16'h2222);

        // R5 chip select high
        latch_addr(9'h003);
        @(negedge clk);
        rd_n_i = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 no ready without select", 16'(ready_n_o), 16'h1);
        check("R5 no lanes without select", 16'(data_oe_o), 16'h0);
        rd_n_i = 1'b1;
        data_i = 16'h0BAD;
        wr_n_i = 1'b0;
        repeat (5) @(negedge clk);
        wr_n_i = 1'b1;
        repeat (5) @(negedge clk);
        bus_read(rd, oe);
        check("R5 write without select ignored", rd, 16'hA5C3);

        // R8 alternate mode
        mode_alt_i = 1'b1;
        @(negedge clk);
        data_i = 16'hDEAD;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 ready high in alt mode", 16'(ready_n_o), 16'h1);
        wr_n_i = 1'b1;
        repeat (3) @(negedge clk);
        rd_n_i = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 lanes off in alt mode", 16'(data_oe_o), 16'h0);
        rd_n_i = 1'b1;
        repeat (5) @(negedge clk);
        cs_n_i = 1'b1;
        mode_alt_i = 1'b0;
        bus_read(rd, oe);
        check("R8 write ignored in alt mode", rd, 16'hA5C3);

        // R9 interrupt enable / pending
        latch_addr(9'h1FE);
        bus_write(16'h0005);
        @(negedge clk);
        irq_src_i = 8'h02;
        @(negedge clk);
        irq_src_i = 8'h00;
        @(negedge clk);
        check("R9 masked source no request", 16'(irq_n_o), 16'h1);
        irq_src_i = 8'h04;
        @(negedge clk);
        irq_src_i = 8'h00;
        @(negedge clk);
        check("R9 enabled source requests", 16'(irq_n_o), 16'h0);
        latch_addr(9'h1FF);
        bus_read(rd, oe);
        check("R9 pending readback", rd, 16'h0006);
        bus_write(16'h0004);
        @(negedge clk);
        check("R9 cleared request", 16'(irq_n_o), 16'h1);
        bus_read(rd, oe);
        check("R9 other pending kept", rd, 16'h0002);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule